// File: doc/BRIEF.md
# Integer Status Flag Generator

This block derives the integer status flags that follow a 64-bit ALU operation. The ALU result and its operands come in together. Before any flag is derived, operand A may be bitwise inverted and operand B may be replaced by an immediate. From these the block produces:

- a full-width carry and a low-half carry;
- a full-width signed overflow and a low-half signed overflow;
- a sticky summary-overflow bit;
- a 4-bit condition field when the result is to be recorded.

Each flag group has its own enable. A 2-bit mask lets an instruction that writes its own carry bits keep them from being overwritten here. When a divide overflow is supplied from outside, it takes the place of the derived overflow.

All outputs are registered. Each flag keeps its last written value until a later operation writes it. A one-cycle write-enable pulse goes with every update, so the surrounding state can be refreshed selectively.

Top module: `alu_flag_unit`

## Requirements
- R1: Outputs update on the rising clock edge at which `op_valid` is high. In the cycle that follows, the matching write-enable output (`ca_we`, `ca32_we`, `ov_we`, `cr_we`) is high for exactly one cycle.
- R2: When `inv_a` is 1, every flag is computed from the bitwise inverse of `op_a`.
- R3: When `imm_valid` is 1, `imm` replaces `op_b` as the second operand in every flag computation.
- R4: `ca` is 1 when the result is unsigned-less-than either operand.
- R5: When `is_add` is 1, `ca32` is the XOR of bit 32 (LSB = bit 0) of the result, of operand A and of operand B.
- R6: When `is_add` is 0, `ca32` is 1 when the low 32 bits of the result are unsigned-less-than the low 32 bits of either operand.
- R7: Bit 0 of `done_mask` blocks the `ca` write and bit 1 blocks the `ca32` write. A blocked flag keeps its value and its write enable stays low.
- R8: `ov` is 1 when both operands have equal bit 63 and the result's bit 63 differs. `ov32` applies the same rule to bit 31.
- R9: When `divov_valid` is 1, both `ov` and `ov32` take `divov_val` in place of the derived values.
- R10: When the overflow flags are written, `so` becomes `so_in` OR the new `ov`. `ov32` does not feed `so`.
- R11: When `rec_en` is 1, `cr_field` is {negative, positive, zero, summary} from bit 3 down to bit 0. Negative, positive and zero are judged on the result as a signed 64-bit value. The summary bit is the `so` value written by the same operation, or `so_in` if overflow is not enabled.
- R12: When `carry_en`, `ov_en` or `rec_en` is 0, the flags that enable governs keep their previous values and their write enables stay low.
- R13: While `rst_n` is low, all flag outputs, `cr_field` and all write enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is present this cycle |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Operand B |
| inv_a | input | 1 | Invert operand A before flag computation |
| imm_valid | input | 1 | Use `imm` as the second operand |
| imm | input | 64 | Immediate operand |
| result | input | 64 | ALU result |
| is_add | input | 1 | Operation is an addition (selects the CA32 rule) |
| carry_en | input | 1 | Write carry flags |
| ov_en | input | 1 | Write overflow flags and summary overflow |
| rec_en | input | 1 | Write the condition field |
| divov_valid | input | 1 | An external divide overflow is supplied |
| divov_val | input | 1 | External divide overflow value |
| done_mask | input | 2 | Carry writes already done (bit 0 CA, bit 1 CA32) |
| so_in | input | 1 | Current summary overflow |
| ca | output | 1 | Carry |
| ca32 | output | 1 | Low-half carry |
| ov | output | 1 | Overflow |
| ov32 | output | 1 | Low-half overflow |
| so | output | 1 | Sticky summary overflow |
| cr_field | output | 4 | Condition field {neg, pos, zero, so} |
| ca_we | output | 1 | `ca` was written |
| ca32_we | output | 1 | `ca32` was written |
| ov_we | output | 1 | `ov`, `ov32` and `so` were written |
| cr_we | output | 1 | `cr_field` was written |

## Verification
The assertions assume that `so_in`, `done_mask` and `divov_*` are stable for the cycle in which `op_valid` is high. The bench meets this by changing inputs only on falling edges and holding them for a full cycle. The assertions also take the result as an arbitrary 64-bit value that need not be the true sum. For that reason the bench pairs each result with hand-chosen operands and does not derive the result from them. It also sets the enables and the mask to fixed values per operation, so the hold and write-pulse checks see known write patterns.

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
  parameter int DW = 64,
  parameter int HW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic          inv_a,
  input  logic          imm_valid,
  input  logic [DW-1:0] imm,
  input  logic [DW-1:0] result,
  input  logic          is_add,
  input  logic          carry_en,
  input  logic          ov_en,
  input  logic          rec_en,
  input  logic          divov_valid,
  input  logic          divov_val,
  input  logic [1:0]    done_mask,
  input  logic          so_in,
  output logic          ca,
  output logic          ca32,
  output logic          ov,
  output logic          ov32,
  output logic          so,
  output logic [3:0]    cr_field,
  output logic          ca_we,
  output logic          ca32_we,
  output logic          ov_we,
  output logic          cr_we
);
  logic [DW-1:0] a_eff, b_eff;
  logic          c_full, c_half, o_full, o_half, so_nxt;
  logic          neg, zer, pos;
  logic          w_ca, w_ca32, w_ov, w_cr;

  assign a_eff  = inv_a ? ~op_a : op_a;
  assign b_eff  = imm_valid ? imm : op_b;

  assign c_full = (result < a_eff) || (result < b_eff);
  assign c_half = is_add ? (result[HW] ^ a_eff[HW] ^ b_eff[HW])
                         : ((result[HW-1:0] < a_eff[HW-1:0]) ||
                            (result[HW-1:0] < b_eff[HW-1:0]));

  assign o_full = divov_valid ? divov_val
                : (a_eff[DW-1] == b_eff[DW-1]) && (result[DW-1] != a_eff[DW-1]);
  assign o_half = divov_valid ? divov_val
                : (a_eff[HW-1] == b_eff[HW-1]) && (result[HW-1] != a_eff[HW-1]);
  assign so_nxt = ov_en ? (so_in | o_full) : so_in;

  assign neg    = result[DW-1];
  assign zer    = (result == '0);
  assign pos    = !neg && !zer;

  assign w_ca   = op_valid && carry_en && !done_mask[0];
  assign w_ca32 = op_valid && carry_en && !done_mask[1];
  assign w_ov   = op_valid && ov_en;
  assign w_cr   = op_valid && rec_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ca <= 1'b0; ca32 <= 1'b0; ov <= 1'b0; ov32 <= 1'b0; so <= 1'b0;
      cr_field <= '0;
      ca_we <= 1'b0; ca32_we <= 1'b0; ov_we <= 1'b0; cr_we <= 1'b0;
    end else begin
      ca_we   <= w_ca;
      ca32_we <= w_ca32;
      ov_we   <= w_ov;
      cr_we   <= w_cr;
      if (w_ca)   ca   <= c_full;
      if (w_ca32) ca32 <= c_half;
      if (w_ov) begin
        ov   <= o_full;
        ov32 <= o_half;
        so   <= so_nxt;
      end
      if (w_cr) cr_field <= {neg, pos, zer, so_nxt};
    end
  end
endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic       carry_en,
  input logic       divov_valid,
  input logic [1:0] done_mask,
  input logic       so_in,
  input logic       ca,
  input logic       ca32,
  input logic       ov,
  input logic       ov32,
  input logic       so,
  input logic [3:0] cr_field,
  input logic       ca_we,
  input logic       ca32_we,
  input logic       ov_we,
  input logic       cr_we
);
  // R12
  ca_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ca_we |-> $stable(ca));
  // R12
  cr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cr_we |-> $stable(cr_field));
  // R7
  ca_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ca_we |-> $past(op_valid && carry_en && !done_mask[0]));
  // R7
  ca32_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ca32_we |-> $past(!done_mask[1]));
  // R9
  div_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_we && $past(divov_valid)) |-> (ov == ov32));
  // R10
  so_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_we && (ov || $past(so_in))) |-> so);
  // R11
  cr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> ($countones(cr_field[3:1]) == 1));
  // R1
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_we || cr_we || ca_we || ca32_we) |-> $past(op_valid));
endmodule

bind alu_flag_unit alu_flag_unit_chk chk (.*);

// File: tb/alu_flag_unit_test.sv
`timescale 1ns/1ps
module alu_flag_unit_test;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic op_valid = 0, inv_a = 0, imm_valid = 0, is_add = 0;
  logic carry_en = 0, ov_en = 0, rec_en = 0, divov_valid = 0, divov_val = 0, so_in = 0;
  logic [1:0] done_mask = 0;
  logic [63:0] op_a = 0, op_b = 0, imm = 0, result = 0;
  logic ca, ca32, ov, ov32, so, ca_we, ca32_we, ov_we, cr_we;
  logic [3:0] cr_field;

  int checks = 0, errors = 0;

  alu_flag_unit uut (.*);

  localparam int NV = 6;
  localparam logic [63:0] TA [NV] = '{64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF,
                                     64'h7FFF_FFFF, 64'h1_0000_0000, 64'h2};
  localparam logic [63:0] TB [NV] = '{64'h2, 64'h1, 64'h1, 64'h1, 64'hFFFF_FFFF, 64'h3};
  localparam logic [63:0] TR [NV] = '{64'h3, 64'h0, 64'h8000_0000_0000_0000,
                                     64'h8000_0000, 64'h5, 64'h5};
  localparam logic [NV-1:0] TADD = 6'b101111;
  localparam logic [NV-1:0] TSO  = 6'b100000;
  // {ca, ca32, ov, ov32, so, cr_field}
  localparam logic [8:0] TEXP [NV] = '{9'b0_0_0_0_0_0100, 9'b1_1_0_0_0_0010, 9'b0_1_1_0_1_1001,
                                      9'b0_0_0_1_0_0100, 9'b1_1_0_0_0_0100, 9'b0_0_0_0_1_0101};

  task automatic check(input string req, input logic [12:0] got, input logic [12:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  function automatic logic [12:0] snap();
    return {ca, ca32, ov, ov32, so, cr_field, ca_we, ca32_we, ov_we, cr_we};
  endfunction

  task automatic op(input logic [63:0] a, input logic [63:0] b, input logic [63:0] r,
                    input logic add, input logic sin);
    @(negedge clk);
    op_a = a; op_b = b; result = r; is_add = add; so_in = sin; op_valid = 1;
    @(negedge clk);
    op_valid = 0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R13 reset", snap(), 13'b0);
    rst_n = 1;
    carry_en = 1; ov_en = 1; rec_en = 1;

    // R4 R5 R6 R8 R10 R11 R1: table walk
    for (int i = 0; i < NV; i++) begin
      op(TA[i], TB[i], TR[i], TADD[i], TSO[i]);
      check($sformatf("R4/R5/R6/R8/R10/R11 vec%0d", i), snap(), {TEXP[i], 4'b1111});
    end

    // R1: write enables drop after one cycle
    @(negedge clk);
    check("R1 we pulse", {ca_we, ca32_we, ov_we, cr_we}, 4'b0000);

    // R2: inverted zero acts as all-ones
    inv_a = 1;
    op(64'h0, 64'h1, 64'h0, 1, 0);
    inv_a = 0;
    check("R2 invert", snap(), {9'b1_1_0_0_0_0010, 4'b1111});

    // R3: immediate replaces a large B
    imm_valid = 1; imm = 64'h1;
    op(64'h5, 64'hFFFF_FFFF_FFFF_FFFF, 64'h6, 1, 0);
    imm_valid = 0;
    check("R3 immediate", snap(), {9'b0_0_0_0_0_0100, 4'b1111});

    // R9: divide overflow forced high
    divov_valid = 1; divov_val = 1;
    op(64'h1, 64'h2, 64'h3, 1, 0);
    check("R9 div high", snap(), {9'b0_0_1_1_1_0101, 4'b1111});
    // R9: divide overflow forced low on an overflowing pattern
    divov_val = 0;
    op(64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 64'h8000_0000_0000_0000, 1, 0);
    divov_valid = 0;
    check("R9 div low", snap(), {9'b0_1_0_0_0_1000, 4'b1111});

    // R7: set ca=1, then mask CA write on a non-carry op
    op(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h0, 1, 0);
    done_mask = 2'b01;
    op(64'h1, 64'h2, 64'h3, 1, 0);
    check("R7 mask ca", snap(), {9'b1_0_0_0_0_0100, 4'b0111});
    op(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h0, 1, 0);
    done_mask = 2'b10;
    op(64'h1, 64'h2, 64'h3, 1, 0);
    done_mask = 2'b00;
    check("R7 mask ca32", snap(), {9'b0_1_0_0_0_0100, 4'b1011});

    // R12: all enables low, flags hold
    op(64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 64'h8000_0000_0000_0000, 1, 0);
    carry_en = 0; ov_en = 0; rec_en = 0;
    op(64'h1, 64'h2, 64'h3, 1, 0);
    check("R12 hold", snap(), {9'b0_1_1_0_1_1001, 4'b0000});

    // R11/R12: record only, SO summary taken from so_in
    rec_en = 1;
    op(64'h1, 64'h1, 64'h0, 1, 1);
    check("R11 zero with so_in", snap(), {9'b0_1_1_0_1_0011, 4'b0001});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule